// File: doc/BRIEF.md
# Parallel flash command sequence decoder

This block watches the write cycles of a byte-wide parallel NOR flash bus and recognises the multi-write command sequences that software issues. Each accepted write is an address plus a data byte. Most commands start with a two-write unlock: AAh written to the coded address 5555h, then 55h written to 2AAAh. A command byte written to 5555h follows. The decoder turns every complete sequence into a registered, single-cycle operation strobe. It carries the target address and data where the operation needs them.

Erase needs a longer sequence: the unlock, the command 80h, a second unlock, and then a final byte. For block erase, more block addresses can be added while a quiet-time window stays open. When the window runs out, the decoder issues one strobe that carries a bitmask of all the selected blocks. Suspend and resume are single writes. A suspend is honoured only while the external engine reports an erase running, and a resume only while it reports an erase suspended.

The decoder also keeps the read mode, either array or auto-select. In auto-select mode it supplies the identification and block-protection byte for the current read address. Any write that does not fit a known sequence drops the decoder back to array mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, all strobes are low, `asel_mode_o` is 0 (array mode) and `erase_window_o` is 0.
- R2: Only address bits [14:0] are matched against the coded addresses 5555h and 2AAAh. Bits above bit 14 do not affect the match. A write to any other value of bits [14:0] breaks the sequence.
- R3: In idle, a write of F0h to any address pulses `reset_stb_o` and selects array mode. The same happens when F0h is written to 5555h as the third write of a sequence.
- R4: Unlock followed by 90h to 5555h pulses `asel_stb_o` and sets `asel_mode_o` to 1. The mode holds until a later sequence completes or is rejected.
- R5: `asel_data_o` decodes `rd_addr_i[1:0]` as follows: 00 gives `MFR_CODE`, 01 gives `DEV_CODE`, and 11 gives 00h. For 10, the output is {7'b0, `blk_prot_i[b]`}, where b = `rd_addr_i[AW-1:BLK_LSB]`.
- R6: Unlock, then A0h to 5555h, then any write: the fourth write pulses `prog_stb_o` one cycle after it is accepted. The strobe carries that write's address and data on `prog_addr_o`/`prog_data_o`.
- R7: Unlock, 80h, unlock, then 10h to 5555h pulses `chip_erase_stb_o`.
- R8: Unlock, 80h, unlock, then 30h to any address opens the block window and sets `erase_window_o` to 1. Each further 30h write adds block `wr_addr_i[AW-1:BLK_LSB]` and restarts the count. `TIMEOUT` cycles after the last accepted block write, `blk_erase_stb_o` pulses with `blk_mask_o` holding one bit per selected block, and the window closes.
- R9: A write that does not fit the current step of a sequence returns the decoder to idle, selects array mode and produces no strobe. This includes a non-30h write while the window is open, which discards the selected blocks.
- R10: While `busy_i` is 1 in idle, every write is ignored except B0h, which pulses `suspend_stb_o`.
- R11: B0h with `busy_i` at 0 produces no strobe. A single write of 30h pulses `resume_stb_o` only when `suspended_i` is 1 and `busy_i` is 0.
- R12: While `suspended_i` is 1, the 80h command is rejected as in R9. The program sequence still works.
- R13: Every strobe lasts exactly one cycle, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write accepted this cycle |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | 8 | Write data byte |
| rd_addr_i | input | AW | Read address for auto-select data |
| busy_i | input | 1 | Erase engine running |
| suspended_i | input | 1 | Erase engine suspended |
| blk_prot_i | input | NBLK | Per-block protection status |
| asel_mode_o | output | 1 | 1 = auto-select read mode, 0 = array |
| asel_data_o | output | 8 | Auto-select read byte |
| reset_stb_o | output | 1 | Read/reset strobe |
| asel_stb_o | output | 1 | Auto-select entry strobe |
| prog_stb_o | output | 1 | Program strobe |
| prog_addr_o | output | AW | Program target address |
| prog_data_o | output | 8 | Program data |
| chip_erase_stb_o | output | 1 | Chip erase strobe |
| blk_erase_stb_o | output | 1 | Block erase start strobe |
| blk_mask_o | output | NBLK | Selected blocks, valid with the block erase strobe |
| erase_window_o | output | 1 | Block address window open |
| suspend_stb_o | output | 1 | Erase suspend strobe |
| resume_stb_o | output | 1 | Erase resume strobe |

## Verification
The bench builds the decoder with AW=16, BLK_LSB=13 and TIMEOUT=6. This gives eight blocks, and bit 15 becomes the only ignored upper address bit. With eight blocks, all 255 non-empty block masks can be built up inside the window and checked against the exact expiry cycle. With only eight blocks, the full 32-entry auto-select map can also be swept. A six-cycle window makes the restart-on-add timing cheap to reach. Every third-cycle command byte is swept to confirm the fall-back to array mode.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_ERA1, ST_ERA2, ST_ERA3, ST_BWIN
  } seq_st_e;

  localparam int unsigned CODED_BITS = 15;
  localparam logic [CODED_BITS-1:0] ADDR_KEY_A = 15'h5555;
  localparam logic [CODED_BITS-1:0] ADDR_KEY_B = 15'h2AAA;

  localparam logic [7:0] BYTE_KEY_A = 8'hAA;
  localparam logic [7:0] BYTE_KEY_B = 8'h55;
  localparam logic [7:0] OP_RESET   = 8'hF0;
  localparam logic [7:0] OP_ASEL    = 8'h90;
  localparam logic [7:0] OP_PROG    = 8'hA0;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_CHIP    = 8'h10;
  localparam logic [7:0] OP_BLOCK   = 8'h30;
  localparam logic [7:0] OP_SUSP    = 8'hB0;
  localparam logic [7:0] OP_RESUME  = 8'h30;
endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
(
  input  logic [CODED_BITS-1:0] addr_i,
  output logic                  hit_a_o,
  output logic                  hit_b_o
);
  assign hit_a_o = (addr_i == ADDR_KEY_A);
  assign hit_b_o = (addr_i == ADDR_KEY_B);
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW      = 20,
  parameter int unsigned BLK_LSB = 13,
  localparam int unsigned BW     = AW - BLK_LSB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          hit_a_i,
  input  logic          hit_b_i,
  input  logic          busy_i,
  input  logic          suspended_i,
  input  logic          win_expire_i,
  output logic          win_load_o,
  output logic          win_fresh_o,
  output logic          win_abort_o,
  output logic [BW-1:0] win_blk_o,
  output logic          asel_mode_o,
  output logic          reset_stb_o,
  output logic          asel_stb_o,
  output logic          prog_stb_o,
  output logic [AW-1:0] prog_addr_o,
  output logic [7:0]    prog_data_o,
  output logic          chip_stb_o,
  output logic          susp_stb_o,
  output logic          resume_stb_o
);
  seq_st_e st_q, st_d;
  logic mode_q, mode_d;
  logic rst_d, asel_d, prog_d, chip_d, susp_d, res_d;
  logic rst_q, asel_q, prog_q, chip_q, susp_q, res_q;
  logic [AW-1:0] paddr_q, paddr_d;
  logic [7:0]    pdata_q, pdata_d;

  assign win_blk_o = wr_addr_i[AW-1:BLK_LSB];

  always_comb begin
    st_d = st_q;
    mode_d = mode_q;
    paddr_d = paddr_q;
    pdata_d = pdata_q;
    {rst_d, asel_d, prog_d, chip_d, susp_d, res_d} = '0;
    win_load_o = 1'b0;
    win_fresh_o = 1'b0;
    win_abort_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (wr_en_i) begin
        if (busy_i) begin
          susp_d = (wr_data_i == OP_SUSP);
        end else if (wr_data_i == OP_RESET) begin
          rst_d = 1'b1;
          mode_d = 1'b0;
        end else if (hit_a_i && wr_data_i == BYTE_KEY_A) begin
          st_d = ST_UNL1;
        end else if (suspended_i && wr_data_i == OP_RESUME) begin
          res_d = 1'b1;
        end else begin
          mode_d = 1'b0;
        end
      end
      ST_UNL1: if (wr_en_i) begin
        if (hit_b_i && wr_data_i == BYTE_KEY_B) st_d = ST_UNL2;
        else begin st_d = ST_IDLE; mode_d = 1'b0; end
      end
      ST_UNL2: if (wr_en_i) begin
        st_d = ST_IDLE;
        mode_d = 1'b0;
        if (hit_a_i) begin
          case (wr_data_i)
            OP_RESET: rst_d = 1'b1;
            OP_ASEL:  begin asel_d = 1'b1; mode_d = 1'b1; end
            OP_PROG:  st_d = ST_PROG;
            OP_ERASE: if (!suspended_i) st_d = ST_ERA1;
            default:  ;
          endcase
        end
      end
      ST_PROG: if (wr_en_i) begin
        prog_d = 1'b1;
        paddr_d = wr_addr_i;
        pdata_d = wr_data_i;
        mode_d = 1'b0;
        st_d = ST_IDLE;
      end
      ST_ERA1: if (wr_en_i) begin
        if (hit_a_i && wr_data_i == BYTE_KEY_A) st_d = ST_ERA2;
        else begin st_d = ST_IDLE; mode_d = 1'b0; end
      end
      ST_ERA2: if (wr_en_i) begin
        if (hit_b_i && wr_data_i == BYTE_KEY_B) st_d = ST_ERA3;
        else begin st_d = ST_IDLE; mode_d = 1'b0; end
      end
      ST_ERA3: if (wr_en_i) begin
        mode_d = 1'b0;
        st_d = ST_IDLE;
        if (hit_a_i && wr_data_i == OP_CHIP) begin
          chip_d = 1'b1;
        end else if (wr_data_i == OP_BLOCK) begin
          win_load_o = 1'b1;
          win_fresh_o = 1'b1;
          st_d = ST_BWIN;
        end
      end
      ST_BWIN: begin
        if (wr_en_i) begin
          if (wr_data_i == OP_BLOCK) begin
            win_load_o = 1'b1;
          end else begin
            win_abort_o = 1'b1;
            st_d = ST_IDLE;
            mode_d = 1'b0;
          end
        end else if (win_expire_i) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      mode_q <= 1'b0;
      {rst_q, asel_q, prog_q, chip_q, susp_q, res_q} <= '0;
      paddr_q <= '0;
      pdata_q <= '0;
    end else begin
      st_q <= st_d;
      mode_q <= mode_d;
      {rst_q, asel_q, prog_q, chip_q, susp_q, res_q} <=
        {rst_d, asel_d, prog_d, chip_d, susp_d, res_d};
      paddr_q <= paddr_d;
      pdata_q <= pdata_d;
    end
  end

  assign asel_mode_o  = mode_q;
  assign reset_stb_o  = rst_q;
  assign asel_stb_o   = asel_q;
  assign prog_stb_o   = prog_q;
  assign prog_addr_o  = paddr_q;
  assign prog_data_o  = pdata_q;
  assign chip_stb_o   = chip_q;
  assign susp_stb_o   = susp_q;
  assign resume_stb_o = res_q;

  AST_BUSY_HOLDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && busy_i && wr_en_i) |=> (st_q == ST_IDLE && !rst_q && !prog_q)); // R10
  AST_SUSP_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_q |-> $past(busy_i)); // R11
  AST_RESUME_NEEDS_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_q |-> $past(suspended_i && !busy_i)); // R11
  AST_ERASE_NOT_SUSPENDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ERA1 && $past(st_q) == ST_UNL2) |-> !$past(suspended_i)); // R12
  AST_PROG_AFTER_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_q |-> $past(st_q == ST_PROG && wr_en_i)); // R6
  AST_ASEL_SETS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asel_q |-> mode_q); // R4
endmodule

// File: rtl/flash_blk_window.sv
module flash_blk_window #(
  parameter int unsigned NBLK    = 128,
  parameter int unsigned TIMEOUT = 4096,
  localparam int unsigned BW     = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int unsigned CW     = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            load_i,
  input  logic            fresh_i,
  input  logic            abort_i,
  input  logic [BW-1:0]   blk_i,
  output logic            expire_o,
  output logic            open_o,
  output logic            stb_o,
  output logic [NBLK-1:0] mask_o
);
  logic            open_q, stb_q;
  logic [CW-1:0]   cnt_q;
  logic [NBLK-1:0] acc_q, out_q, bit_sel;

  assign bit_sel  = NBLK'(1) << blk_i;
  assign expire_o = open_q && (cnt_q == '0) && !wr_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      stb_q  <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      out_q  <= '0;
    end else begin
      stb_q <= 1'b0;
      if (load_i) begin
        open_q <= 1'b1;
        cnt_q  <= CW'(TIMEOUT - 1);
        acc_q  <= fresh_i ? bit_sel : (acc_q | bit_sel);
      end else if (abort_i) begin
        open_q <= 1'b0;
        acc_q  <= '0;
      end else if (expire_o) begin
        open_q <= 1'b0;
        stb_q  <= 1'b1;
        out_q  <= acc_q;
        acc_q  <= '0;
      end else if (open_q) begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign open_o = open_q;
  assign stb_o  = stb_q;
  assign mask_o = out_q;

  AST_MASK_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> (out_q != '0)); // R8
  AST_EXPIRE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> ($past(open_q) && !$past(wr_en_i))); // R8
  AST_CLOSE_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> !open_q); // R8
  AST_LOAD_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> open_q); // R8
endmodule

// File: rtl/flash_asel_rom.sv
module flash_asel_rom #(
  parameter int unsigned NBLK     = 128,
  parameter logic [7:0]  MFR_CODE = 8'h20,
  parameter logic [7:0]  DEV_CODE = 8'hD2,
  localparam int unsigned BW      = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic [1:0]      sel_i,
  input  logic [BW-1:0]   blk_i,
  input  logic [NBLK-1:0] prot_i,
  output logic [7:0]      data_o
);
  always_comb begin
    unique case (sel_i)
      2'b00:   data_o = MFR_CODE;
      2'b01:   data_o = DEV_CODE;
      2'b10:   data_o = {7'b0, prot_i[blk_i]};
      default: data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW       = 20,
  parameter int unsigned BLK_LSB  = 13,
  parameter int unsigned TIMEOUT  = 4096,
  parameter logic [7:0]  MFR_CODE = 8'h20,
  parameter logic [7:0]  DEV_CODE = 8'hD2,
  localparam int unsigned BW      = AW - BLK_LSB,
  localparam int unsigned NBLK    = 1 << BW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [7:0]      wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  input  logic            busy_i,
  input  logic            suspended_i,
  input  logic [NBLK-1:0] blk_prot_i,
  output logic            asel_mode_o,
  output logic [7:0]      asel_data_o,
  output logic            reset_stb_o,
  output logic            asel_stb_o,
  output logic            prog_stb_o,
  output logic [AW-1:0]   prog_addr_o,
  output logic [7:0]      prog_data_o,
  output logic            chip_erase_stb_o,
  output logic            blk_erase_stb_o,
  output logic [NBLK-1:0] blk_mask_o,
  output logic            erase_window_o,
  output logic            suspend_stb_o,
  output logic            resume_stb_o
);
  logic hit_a, hit_b;
  logic win_load, win_fresh, win_abort, win_expire;
  logic [BW-1:0] win_blk;
  logic unused_rd;

  assign unused_rd = ^rd_addr_i[BLK_LSB-1:2];

  flash_cmd_match u_match (
    .addr_i  (wr_addr_i[CODED_BITS-1:0]),
    .hit_a_o (hit_a),
    .hit_b_o (hit_b)
  );

  flash_cmd_fsm #(.AW(AW), .BLK_LSB(BLK_LSB)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .hit_a_i      (hit_a),
    .hit_b_i      (hit_b),
    .busy_i       (busy_i),
    .suspended_i  (suspended_i),
    .win_expire_i (win_expire),
    .win_load_o   (win_load),
    .win_fresh_o  (win_fresh),
    .win_abort_o  (win_abort),
    .win_blk_o    (win_blk),
    .asel_mode_o  (asel_mode_o),
    .reset_stb_o  (reset_stb_o),
    .asel_stb_o   (asel_stb_o),
    .prog_stb_o   (prog_stb_o),
    .prog_addr_o  (prog_addr_o),
    .prog_data_o  (prog_data_o),
    .chip_stb_o   (chip_erase_stb_o),
    .susp_stb_o   (suspend_stb_o),
    .resume_stb_o (resume_stb_o)
  );

  flash_blk_window #(.NBLK(NBLK), .TIMEOUT(TIMEOUT)) u_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .load_i   (win_load),
    .fresh_i  (win_fresh),
    .abort_i  (win_abort),
    .blk_i    (win_blk),
    .expire_o (win_expire),
    .open_o   (erase_window_o),
    .stb_o    (blk_erase_stb_o),
    .mask_o   (blk_mask_o)
  );

  flash_asel_rom #(.NBLK(NBLK), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_asel (
    .sel_i  (rd_addr_i[1:0]),
    .blk_i  (rd_addr_i[AW-1:BLK_LSB]),
    .prot_i (blk_prot_i),
    .data_o (asel_data_o)
  );

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reset_stb_o, asel_stb_o, prog_stb_o, chip_erase_stb_o,
              blk_erase_stb_o, suspend_stb_o, resume_stb_o})); // R13
  AST_PROG_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_stb_o |=> !prog_stb_o); // R13
  AST_CHIP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_erase_stb_o |=> !chip_erase_stb_o); // R13
endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int BLK_LSB = 13;
  localparam int TMO = 6;
  localparam int NB = 8;
  localparam logic [7:0] MFR = 8'h20;
  localparam logic [7:0] DEV = 8'hD2;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, busy = 0, susp = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [NB-1:0] prot = 0;
  logic asel_mode, reset_stb, asel_stb, prog_stb, chip_stb, blk_stb, win, susp_stb, res_stb;
  logic [7:0] asel_data, prog_data;
  logic [AW-1:0] prog_addr;
  logic [NB-1:0] mask;

  int n_chk = 0, n_fail = 0;
  int c_reset = 0, c_asel = 0, c_prog = 0, c_chip = 0, c_blk = 0, c_susp = 0, c_res = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .BLK_LSB(BLK_LSB), .TIMEOUT(TMO), .MFR_CODE(MFR), .DEV_CODE(DEV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .busy_i(busy), .suspended_i(susp), .blk_prot_i(prot),
    .asel_mode_o(asel_mode), .asel_data_o(asel_data), .reset_stb_o(reset_stb),
    .asel_stb_o(asel_stb), .prog_stb_o(prog_stb), .prog_addr_o(prog_addr),
    .prog_data_o(prog_data), .chip_erase_stb_o(chip_stb), .blk_erase_stb_o(blk_stb),
    .blk_mask_o(mask), .erase_window_o(win), .suspend_stb_o(susp_stb), .resume_stb_o(res_stb));

  // strobe monitor, sampled a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      c_reset += int'(reset_stb); c_asel += int'(asel_stb); c_prog += int'(prog_stb);
      c_chip += int'(chip_stb); c_blk += int'(blk_stb); c_susp += int'(susp_stb);
      c_res += int'(res_stb);
    end
  end

  function automatic int total();
    return c_reset + c_asel + c_prog + c_chip + c_blk + c_susp + c_res;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic unlock(input logic [AW-1:0] hi);
    wr(16'h5555 | hi, 8'hAA);
    wr(16'h2AAA | hi, 8'h55);
  endtask

  task automatic erase_prefix();
    unlock(0); wr(16'h5555, 8'h80); unlock(0);
  endtask

  task automatic enter_asel();
    unlock(0); wr(16'h5555, 8'h90);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 strobes", {reset_stb, asel_stb, prog_stb, chip_stb, blk_stb, susp_stb, res_stb}, 0);
    chk("R1 mode", asel_mode, 0);
    chk("R1 window", win, 0);
    rst_n = 1;
    @(negedge clk);

    // R4 auto-select entry, R5 read map sweep
    enter_asel();
    chk("R4 asel strobe", asel_stb, 1);
    chk("R4 mode", asel_mode, 1);
    for (int p = 0; p < 2; p++) begin
      prot = (p == 0) ? 8'hA5 : 8'h3C;
      for (int b = 0; b < NB; b++)
        for (int s = 0; s < 4; s++) begin
          logic [7:0] e;
          rd_addr = AW'((b << BLK_LSB) | (((b * 37 + s) & 8'hFF) << 2) | s);
          e = (s == 0) ? MFR : (s == 1) ? DEV : (s == 2) ? {7'b0, prot[b]} : 8'h00;
          #1 chk("R5 asel data", asel_data, e);
        end
    end
    @(negedge clk);
    chk("R4 mode held", asel_mode, 1);

    // R3 single-write reset at several addresses
    for (int i = 0; i < 4; i++) begin
      logic [AW-1:0] a;
      a = AW'(i * 16'h4D2B);
      enter_asel();
      wr(a, 8'hF0);
      chk("R3 reset strobe", reset_stb, 1);
      chk("R3 mode array", asel_mode, 0);
    end
    enter_asel();
    unlock(0); wr(16'h5555, 8'hF0);
    chk("R3 third-cycle reset", reset_stb, 1);
    chk("R3 third-cycle mode", asel_mode, 0);

    // R2 upper address bits ignored, lower bits must match
    for (int h = 0; h < 2; h++) begin
      wr(16'h0000, 8'hF0);
      unlock(AW'(h << 15)); wr(16'h5555 | AW'(h << 15), 8'h90);
      chk("R2 upper bits ignored", asel_stb, 1);
    end
    base = total();
    wr(16'h5554, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h90);
    chk("R2 wrong key addr strobes", total() - base, 0);
    chk("R2 wrong key addr mode", asel_mode, 0);

    // R6 program sweep, R13 pulse width
    for (int i = 0; i < 16; i++) begin
      logic [AW-1:0] a; logic [7:0] d;
      a = AW'(i * 16'h1111) ^ 16'h0F0F;
      d = 8'(i * 17 + 3);
      base = c_prog;
      unlock(0); wr(16'h5555, 8'hA0);
      chk("R6 no early strobe", c_prog - base, 0);
      wr(a, d);
      chk("R6 prog strobe", prog_stb, 1);
      chk("R6 prog addr", prog_addr, a);
      chk("R6 prog data", prog_data, d);
      @(negedge clk);
      chk("R13 one cycle", prog_stb, 0);
    end

    // R7 chip erase
    erase_prefix(); wr(16'hD555, 8'h10);
    chk("R7 chip strobe", chip_stb, 1);
    @(negedge clk);
    chk("R13 chip one cycle", chip_stb, 0);

    // R8 every block mask
    for (int m = 1; m < 256; m++) begin
      bit first = 1;
      erase_prefix();
      for (int b = 0; b < NB; b++)
        if (m[b]) begin
          wr(AW'((b << BLK_LSB) | 16'h0123), 8'h30);
          first = 0;
        end
      chk("R8 window open", win, 1);
      base = c_blk;
      repeat (TMO - 1) @(negedge clk);
      chk("R8 no early start", c_blk - base + int'(blk_stb), 0);
      @(negedge clk);
      chk("R8 start strobe", blk_stb, 1);
      chk("R8 mask", mask, m);
      chk("R8 window closed", win, 0);
    end
    // R8 restart on add
    erase_prefix(); wr(16'h0000, 8'h30);
    repeat (TMO - 2) @(negedge clk);
    wr(16'h6000, 8'h30);
    base = c_blk;
    repeat (TMO - 1) @(negedge clk);
    chk("R8 restart no early", c_blk - base + int'(blk_stb), 0);
    @(negedge clk);
    chk("R8 restart strobe", blk_stb, 1);
    chk("R8 restart mask", mask, 8'h09);

    // R9 unrecognised third-cycle bytes
    for (int c = 0; c < 256; c++) begin
      if (c == 8'hF0 || c == 8'h90 || c == 8'hA0 || c == 8'h80) continue;
      enter_asel();
      base = total();
      unlock(0); wr(16'h5555, 8'(c));
      chk("R9 no strobe", total() - base, 0);
      chk("R9 mode array", asel_mode, 0);
    end
    enter_asel();
    base = total();
    erase_prefix(); wr(16'h5555, 8'h20);
    chk("R9 bad erase byte", total() - base, 0);
    chk("R9 bad erase mode", asel_mode, 0);
    erase_prefix(); wr(16'h2000, 8'h30);
    base = total();
    wr(16'h0000, 8'h55);
    repeat (TMO + 2) @(negedge clk);
    chk("R9 window abort strobes", total() - base, 0);
    chk("R9 window abort closed", win, 0);

    // R10 busy blocks sequences, honours suspend
    busy = 1;
    base = total();
    unlock(0); wr(16'h5555, 8'hA0); wr(16'h0100, 8'h12); wr(16'h0000, 8'hF0);
    chk("R10 busy ignores", total() - base, 0);
    wr(16'h3333, 8'hB0);
    chk("R10 suspend strobe", susp_stb, 1);
    busy = 0;

    // R11 suspend/resume qualification
    base = total();
    wr(16'h1234, 8'hB0); wr(16'h1234, 8'h30);
    chk("R11 ignored when idle", total() - base, 0);
    susp = 1;
    wr(16'h4321, 8'h30);
    chk("R11 resume strobe", res_stb, 1);

    // R12 erase rejected while suspended, program allowed
    base = total();
    erase_prefix(); wr(16'h5555, 8'h10);
    chk("R12 erase rejected", total() - base, 0);
    unlock(0); wr(16'h5555, 8'hA0); wr(16'h0456, 8'h7E);
    chk("R12 program allowed", prog_stb, 1);
    chk("R12 program addr", prog_addr, 16'h0456);
    susp = 0;

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule